// File: doc/BRIEF.md
# Zero-Sequence Injection PWM Modulator

This block drives the three legs of a two-level, three-phase inverter from a shared symmetric triangle carrier. Three signed fixed-point phase references come in, scaled so that -1.0 and +1.0 mark the negative and positive DC rails. Once per carrier period the block picks a common-mode offset, adds it to all three references, clips the results to the rails, and converts them to counter thresholds. Each leg's upper switch conducts while its threshold is above the carrier. The lower switch is the inverse of the upper switch.

A mode input picks how the offset is formed. Plain sine uses no offset. Min-max centres the reference envelope, which gives the carrier-based form of space-vector modulation. Two discontinuous modes tie the lowest or the highest phase to its rail. A fifth mode ties whichever phase has the larger magnitude to the rail of the same sign, so each leg clamps for 30 degrees on both sides of its peak. References and mode are sampled only at the carrier valley. Changes made during a period therefore never split a pulse. Reference generation and dead time are handled outside the block.

Top module: `zsi_pwm_top`

## Requirements
- R1: In sine mode (mode code 0) the offset is zero. Each phase's modified value equals its reference.
- R2: In min-max mode (code 1) the offset is -floor((max+min)/2), where max and min are the largest and smallest of the three references.
- R3: In clamp-low mode (code 2) the offset is -1.0 minus the smallest reference. The smallest phase never turns its upper switch on during the period.
- R4: In clamp-high mode (code 3) the offset is +1.0 minus the largest reference. The largest phase keeps its upper switch on for the whole period.
- R5: In peak-clamp mode (code 4), if max+min >= 0 the offset is +1.0 minus max; otherwise it is -1.0 minus min. A tie in magnitude therefore goes to the positive rail.
- R6: Each modified value (reference plus offset) is saturated to the range [-1.0, +1.0] before it is scaled.
- R7: The carrier counts up through 0..N-1, holding N-1 for two cycles, and then counts back down to 0, again holding the end value. One period is 2N cycles. The threshold is floor((v+1.0)*N/2), and the upper gate is high while threshold > carrier. The upper switch is therefore high for 2*threshold cycles in each period.
- R8: References and mode are sampled only in the last cycle of a period, when the carrier is at 0 and counting down. The new thresholds apply from the next period onward, and input changes at any other time have no effect.
- R9: Mode codes 5, 6 and 7 behave exactly like sine mode.
- R10: The gates are driven only after the first period has been sampled. During reset and throughout the first carrier period after reset, all six gates are low. From then on, each lower gate is the inverse of its upper gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_a_i | input | DATA_W | Phase A reference. Signed, with 1.0 = 2^(DATA_W-2) |
| ref_b_i | input | DATA_W | Phase B reference, in the same format |
| ref_c_i | input | DATA_W | Phase C reference, in the same format |
| mode_i | input | 3 | Offset strategy: 0 sine, 1 min-max, 2 clamp low, 3 clamp high, 4 peak clamp |
| gate_hi_o | output | 3 | Upper switch gates. Bit 0 is phase A, bit 2 is phase C |
| gate_lo_o | output | 3 | Lower switch gates, with the same bit order |

## Verification
The clamp assertions assume that the references are a balanced three-phase set inside the linear range of the chosen mode. Under that condition, the clamped phase sits exactly on a rail and produces a full-period constant gate. The stimulus keeps to such sets, except in the saturation case, which runs in sine mode where no clamp assertion applies. The stability assertions assume the inputs can change at any cycle. For that reason the bench changes references in the middle of a period on purpose, and checks that the duty of that period is unaffected.

// File: rtl/zsi_pkg.sv
package zsi_pkg;
  typedef enum logic [2:0] {
    MODE_SINE     = 3'd0,
    MODE_MINMAX   = 3'd1,
    MODE_CLAMP_LO = 3'd2,
    MODE_CLAMP_HI = 3'd3,
    MODE_PEAK30   = 3'd4
  } zsi_mode_e;

  // unused codes fall back to sine
  function automatic zsi_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return MODE_MINMAX;
      3'd2:    return MODE_CLAMP_LO;
      3'd3:    return MODE_CLAMP_HI;
      3'd4:    return MODE_PEAK30;
      default: return MODE_SINE;
    endcase
  endfunction
endpackage

// File: rtl/zsi_carrier.sv
module zsi_carrier #(
  parameter int HALF_PERIOD = 100,
  parameter int CNT_W       = $clog2(HALF_PERIOD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valley_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!down_q) begin
      if (cnt_q == TOP) down_q <= 1'b1;
      else              cnt_q  <= cnt_q + 1'b1;
    end else begin
      if (cnt_q == '0) down_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign valley_o = down_q && (cnt_q == '0);
endmodule

// File: rtl/zsi_offset.sv
module zsi_offset
  import zsi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = DATA_W + 3
) (
  input  logic [2:0][DATA_W-1:0] refs_i,
  input  zsi_mode_e              mode_i,
  output logic signed [EXT_W-1:0] off_o
);
  localparam logic signed [EXT_W-1:0] ONE = EXT_W'(1) <<< (DATA_W - 2);

  logic signed [EXT_W-1:0] ext [3];
  logic signed [EXT_W-1:0] mx, mn, sum;

  for (genvar g = 0; g < 3; g++) begin : g_ext
    assign ext[g] = {{(EXT_W-DATA_W){refs_i[g][DATA_W-1]}}, refs_i[g]};
  end

  always_comb begin
    mx = ext[0];
    mn = ext[0];
    for (int i = 1; i < 3; i++) begin
      if (ext[i] > mx) mx = ext[i];
      if (ext[i] < mn) mn = ext[i];
    end
    sum = mx + mn;
    case (mode_i)
      MODE_MINMAX:   off_o = -(sum >>> 1);
      MODE_CLAMP_LO: off_o = -ONE - mn;
      MODE_CLAMP_HI: off_o = ONE - mx;
      // larger magnitude wins, tie to positive rail
      MODE_PEAK30:   off_o = (sum >= 0) ? (ONE - mx) : (-ONE - mn);
      default:       off_o = '0;
    endcase
  end
endmodule

// File: rtl/zsi_phase_cmp.sv
module zsi_phase_cmp #(
  parameter int DATA_W      = 16,
  parameter int EXT_W       = DATA_W + 3,
  parameter int HALF_PERIOD = 100,
  parameter int CNT_W       = $clog2(HALF_PERIOD + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [DATA_W-1:0]       ref_i,
  input  logic signed [EXT_W-1:0] off_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic [CNT_W-1:0]        thr_o,
  output logic                    hi_o
);
  localparam int PROD_W = DATA_W + CNT_W + 1;
  localparam logic signed [EXT_W-1:0] ONE = EXT_W'(1) <<< (DATA_W - 2);

  logic signed [EXT_W-1:0] ref_ext, mod_v, sat_v, lifted;
  logic [PROD_W-1:0]       prod;
  logic [CNT_W-1:0]        thr_q;

  assign ref_ext = {{(EXT_W-DATA_W){ref_i[DATA_W-1]}}, ref_i};
  assign mod_v   = ref_ext + off_i;

  always_comb begin
    if (mod_v > ONE)       sat_v = ONE;
    else if (mod_v < -ONE) sat_v = -ONE;
    else                   sat_v = mod_v;
  end

  assign lifted = sat_v + ONE;  // 0 .. 2*ONE
  assign prod   = PROD_W'(lifted[DATA_W-1:0]) * PROD_W'(HALF_PERIOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     thr_q <= '0;
    else if (load_i) thr_q <= CNT_W'(prod >> (DATA_W - 1));
  end

  assign thr_o = thr_q;
  assign hi_o  = thr_q > cnt_i;
endmodule

// File: rtl/zsi_pwm_top.sv
module zsi_pwm_top
  import zsi_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_PERIOD = 100,
  localparam int CNT_W      = $clog2(HALF_PERIOD + 1),
  localparam int EXT_W      = DATA_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] ref_a_i,
  input  logic [DATA_W-1:0] ref_b_i,
  input  logic [DATA_W-1:0] ref_c_i,
  input  logic [2:0]        mode_i,
  output logic [2:0]        gate_hi_o,
  output logic [2:0]        gate_lo_o
);
  logic [CNT_W-1:0]            cnt_q;
  logic                        valley;
  logic                        valid_q;
  zsi_mode_e                   mode_q;
  logic [2:0][DATA_W-1:0]      refs;
  logic signed [EXT_W-1:0]     off;
  logic [2:0][CNT_W-1:0]       thr_all;
  logic [2:0]                  hi_raw;

  assign refs = {ref_c_i, ref_b_i, ref_a_i};

  zsi_carrier #(.HALF_PERIOD(HALF_PERIOD), .CNT_W(CNT_W)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_o    (cnt_q),
    .valley_o (valley)
  );

  zsi_offset #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_offset (
    .refs_i (refs),
    .mode_i (decode_mode(mode_i)),
    .off_o  (off)
  );

  for (genvar p = 0; p < 3; p++) begin : g_phase
    zsi_phase_cmp #(
      .DATA_W(DATA_W), .EXT_W(EXT_W), .HALF_PERIOD(HALF_PERIOD), .CNT_W(CNT_W)
    ) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (valley),
      .ref_i  (refs[p]),
      .off_i  (off),
      .cnt_i  (cnt_q),
      .thr_o  (thr_all[p]),
      .hi_o   (hi_raw[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mode_q  <= MODE_SINE;
    end else if (valley) begin
      valid_q <= 1'b1;
      mode_q  <= decode_mode(mode_i);
    end
  end

  assign gate_hi_o = valid_q ? hi_raw  : 3'b000;
  assign gate_lo_o = valid_q ? ~hi_raw : 3'b000;
endmodule

// File: rtl/zsi_pwm_chk.sv
module zsi_pwm_chk #(
  parameter int HALF_PERIOD = 100,
  parameter int CNT_W       = $clog2(HALF_PERIOD + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2:0]            gate_hi_i,
  input logic [2:0]            gate_lo_i,
  input logic [CNT_W-1:0]      cnt_i,
  input logic                  valley_i,
  input logic                  valid_i,
  input logic [2:0]            mode_i,
  input logic [2:0][CNT_W-1:0] thr_i
);
  // R10
  gates_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (gate_hi_i == 3'b000 && gate_lo_i == 3'b000));

  // R10
  gates_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (gate_lo_i == ~gate_hi_i));

  // R7
  carrier_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(HALF_PERIOD - 1));

  // R8
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valley_i |=> $stable(thr_i));

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valley_i |=> $stable(mode_i));

  // R3
  clamp_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd2) |-> (gate_hi_i != 3'b111));

  // R4
  clamp_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd3) |-> (gate_hi_i != 3'b000));
endmodule

bind zsi_pwm_top zsi_pwm_chk #(.HALF_PERIOD(HALF_PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gate_hi_i (gate_hi_o),
  .gate_lo_i (gate_lo_o),
  .cnt_i     (cnt_q),
  .valley_i  (valley),
  .valid_i   (valid_q),
  .mode_i    (mode_q),
  .thr_i     (thr_all)
);

// File: tb/tb_zsi_pwm_top.sv
`timescale 1ns/1ps
module tb_zsi_pwm_top;
  localparam int W   = 16;
  localparam int N   = 16;
  localparam int ONE = 1 << (W - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [2:0] mode = 3'd0;
  logic [2:0] hi, lo;

  int errors = 0;
  int checks = 0;
  int edges = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) edges <= edges + 1;
    else       edges <= 0;
  end

  zsi_pwm_top #(.DATA_W(W), .HALF_PERIOD(N)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ref_a_i(ref_a), .ref_b_i(ref_b), .ref_c_i(ref_c),
    .mode_i(mode), .gate_hi_o(hi), .gate_lo_o(lo)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected upper-on cycles per period, from R1..R7, R9
  function automatic int exp_hi(input int r0, input int r1, input int r2,
                                input int m, input int idx);
    int r[3];
    int mx, mn, off, v;
    longint t;
    r[0] = r0; r[1] = r1; r[2] = r2;
    mx = r0; mn = r0;
    for (int i = 1; i < 3; i++) begin
      if (r[i] > mx) mx = r[i];
      if (r[i] < mn) mn = r[i];
    end
    case (m)
      1: off = -((mx + mn) >>> 1);
      2: off = -ONE - mn;
      3: off = ONE - mx;
      4: off = (mx + mn >= 0) ? (ONE - mx) : (-ONE - mn);
      default: off = 0;
    endcase
    v = r[idx] + off;
    if (v > ONE) v = ONE;
    if (v < -ONE) v = -ONE;
    t = (longint'(v + ONE) * N) >>> (W - 1);
    return 2 * int'(t);
  endfunction

  task automatic sync_start();
    @(negedge clk);
    while (edges % (2 * N) != 0) @(negedge clk);
  endtask

  // samples one period; optional mid-period input change
  task automatic measure(output int cnt[3], output int bad,
                         input bit chg, input int nr0, input int nr1, input int nr2);
    cnt[0] = 0; cnt[1] = 0; cnt[2] = 0; bad = 0;
    for (int i = 0; i < 2 * N; i++) begin
      for (int p = 0; p < 3; p++) if (hi[p]) cnt[p]++;
      if (lo !== ~hi) bad++;
      if (chg && i == N / 2) begin
        ref_a = W'(nr0); ref_b = W'(nr1); ref_c = W'(nr2); mode = 3'd3;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input string req, input int r0, input int r1, input int r2,
                          input int m);
    int c[3];
    int bad;
    sync_start();
    ref_a = W'(r0); ref_b = W'(r1); ref_c = W'(r2); mode = 3'(m);
    repeat (2 * N) @(negedge clk);
    measure(c, bad, 1'b0, 0, 0, 0);
    for (int p = 0; p < 3; p++) check(req, c[p], exp_hi(r0, r1, r2, m, p));
    check("R10 complement", bad, 0);
  endtask

  task automatic test_reset();
    int c[3];
    int lo_cnt;
    check("R10 reset hi", int'(hi), 0);
    check("R10 reset lo", int'(lo), 0);
    @(negedge clk);
    rst_n = 1'b1;
    lo_cnt = 0;
    for (int i = 0; i < 2 * N; i++) begin
      if (lo != 3'b000 || hi != 3'b000) lo_cnt++;
      @(negedge clk);
    end
    check("R10 first period idle", lo_cnt, 0);
    c[0] = 0;
  endtask

  task automatic test_midchange();
    int c[3];
    int bad;
    sync_start();
    ref_a = W'(8192); ref_b = W'(-4096); ref_c = W'(-4096); mode = 3'd0;
    repeat (2 * N) @(negedge clk);
    measure(c, bad, 1'b1, -8192, 4096, 4096);
    for (int p = 0; p < 3; p++)
      check("R8 mid-period change ignored", c[p], exp_hi(8192, -4096, -4096, 0, p));
    check("R10 complement", bad, 0);
    measure(c, bad, 1'b0, 0, 0, 0);
    for (int p = 0; p < 3; p++)
      check("R8 new value next period", c[p], exp_hi(-8192, 4096, 4096, 3, p));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    run_case("R1 sine",            8192, -4096, -4096, 0);
    run_case("R1 sine zero",       0, 0, 0, 0);
    run_case("R2 minmax",          14746, -7373, -7373, 1);
    run_case("R2 minmax skew",     -12000, 9000, 3000, 1);
    run_case("R3 clamp low",       8192, -4096, -4096, 2);
    run_case("R4 clamp high",      8192, -4096, -4096, 3);
    run_case("R5 peak30 positive", 8192, -4096, -4096, 4);
    run_case("R5 peak30 negative", -8192, 4096, 4096, 4);
    run_case("R5 peak30 tie",      4096, -4096, 0, 4);
    run_case("R9 code 7 as sine",  8192, -4096, -4096, 7);
    run_case("R9 code 5 as sine",  -6000, 2000, 4000, 5);
    run_case("R6 saturation",      19661, -19661, 0, 0);
    run_case("R7 full scale",      ONE, -ONE, 0, 0);
    test_midchange();
    report();
  end
endmodule